// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Front End

This block sits between the two open-drain bus lines and the storage core of a serial memory device. It samples the clock and data lines with the system clock and detects the Start and Stop conditions. It takes in eight-bit bytes, most significant bit first, and answers each accepted byte with an acknowledge on the ninth clock. For reads it sends bytes that the storage core supplies and watches the master's answer after each one. The number of bytes between Start and Stop is set entirely by the master.

The storage core sees three things. A received byte arrives on `rx_data_o` with a one-cycle `rx_valid_o` strobe. Read bytes are fetched with a one-cycle `rd_req_o` strobe. A `busy_i` input marks an internal programming cycle. While `busy_i` is high the block acknowledges nothing, not even its own address, so a master can poll for the end of a write. The block drives the data line only by asserting `sda_oe_o`, and the pad then pulls the line low.

Top module: `twi_mem_slave_if`

## Requirements
- R1: After reset, `sda_oe_o`, `rd_req_o` and `rx_valid_o` are all 0.
- R2: When the first byte after a Start has bits 7..1 equal to `DEV_ADDR` (default 7'h50) and `busy_i` is low, the block holds SDA low through the high phase of the ninth SCL pulse. Bit 0 of that byte selects read (1) or write (0).
- R3: When bits 7..1 of the first byte do not match, the block never drives SDA and never strobes `rx_valid_o` or `rd_req_o` until the next Start or Stop.
- R4: In a write, every later byte is acknowledged on its ninth pulse and appears on `rx_data_o` with a single-cycle `rx_valid_o` strobe, in order, for any byte count.
- R5: In a read, `rd_req_o` pulses once after the address acknowledge. The byte on `rd_data_i` in that cycle is consumed and sent most significant bit first.
- R6: After a master acknowledge (SDA low on the ninth pulse of a read byte), `rd_req_o` pulses once for the next byte. After a no-acknowledge, the block keeps SDA released and requests nothing more until a Start or Stop.
- R7: While `busy_i` is high, a matching address byte is not acknowledged. Once `busy_i` is low, the same address is acknowledged again.
- R8: A write data byte received while `busy_i` is high is not acknowledged and gives no `rx_valid_o` strobe.
- R9: `sda_oe_o` changes only while the sampled SCL is low.
- R10: A Stop releases SDA and returns the block to idle.
- R11: A Start seen in the middle of a transfer, even part way through a byte, restarts address reception without any idle period between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_i | input | 1 | Internal programming cycle in progress |
| rx_data_o | output | 8 | Last accepted write data byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte on `rx_data_o` |
| rd_data_i | input | 8 | Next byte to send, consumed when `rd_req_o` is high |
| rd_req_o | output | 1 | One-cycle strobe that takes the byte on `rd_data_i` |

## Verification
The bench acts as the bus master and tries several bus patterns. A matching write separates address acknowledge from data acknowledge. A read with acknowledge, acknowledge and then no-acknowledge shows the bit order and that the data requests stop at the right point. A wrong address and two busy cases (busy at the address, and busy appearing mid-write) show that all acknowledges are withheld. Two repeated Starts, one after a full byte and one after three bits of an address, show that reception restarts cleanly. A monitor also checks that the block's drive on SDA never changes while SCL is high.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_PEND,
        ST_IGNORE
    } state_e;

    typedef struct packed {
        state_e              state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   rx_data;
        logic                sda_oe;
        logic                rx_valid;
        logic                rd_req;
        logic                rw;
    } ctl_s;

endpackage

// File: rtl/twi_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
module twi_sync #(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= {W{RST_VAL}};
                else        q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= {W{RST_VAL}};
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/twi_cond.sv
// Bus condition detector: SCL edges plus Start/Stop from synchronized lines.
module twi_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    // SDA may only move with SCL steadily high for a condition
    assign start_o = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_o  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    assign rise_o  = scl_s & ~scl_p_q;
    assign fall_o  = ~scl_s & scl_p_q;

endmodule

// File: rtl/twi_mem_slave_if.sv
module twi_mem_slave_if
    import twi_mem_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h50,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              busy_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              rd_req_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       start_det, stop_det, scl_rise, scl_fall;
    logic       tx_phase;
    ctl_s       ctl_d, ctl_q;

    twi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    twi_cond cond_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start_det),
        .stop_o  (stop_det),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rx_valid = 1'b0;
        ctl_d.rd_req   = 1'b0;

        if (start_det) begin
            ctl_d.state  = ST_ADDR;
            ctl_d.cnt    = '0;
            ctl_d.sda_oe = 1'b0;
        end else if (stop_det) begin
            ctl_d.state  = ST_IDLE;
            ctl_d.cnt    = '0;
            ctl_d.sda_oe = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && ctl_q.cnt != LAST_BIT) begin
                        ctl_d.shreg = {ctl_q.shreg[BYTE_W-2:0], sda_s};
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                    end else if (scl_fall && ctl_q.cnt == LAST_BIT) begin
                        if (busy_i) begin
                            ctl_d.state = ST_IGNORE;
                        end else if (ctl_q.state == ST_ADDR) begin
                            if (ctl_q.shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                ctl_d.sda_oe = 1'b1;
                                ctl_d.rw     = ctl_q.shreg[0];
                                ctl_d.state  = ST_ADDR_ACK;
                            end else begin
                                ctl_d.state  = ST_IGNORE;
                            end
                        end else begin
                            ctl_d.sda_oe   = 1'b1;
                            ctl_d.rx_valid = 1'b1;
                            ctl_d.rx_data  = ctl_q.shreg;
                            ctl_d.state    = ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.sda_oe = 1'b0;
                        ctl_d.cnt    = '0;
                        if (ctl_q.state == ST_ADDR_ACK && ctl_q.rw) begin
                            ctl_d.rd_req = 1'b1;
                            ctl_d.state  = ST_RD_LOAD;
                        end else begin
                            ctl_d.state  = ST_WR_BYTE;
                        end
                    end
                end
                ST_RD_LOAD: begin
                    ctl_d.shreg  = {rd_data_i[BYTE_W-2:0], 1'b0};
                    ctl_d.sda_oe = ~rd_data_i[BYTE_W-1];
                    ctl_d.cnt    = CNT_W'(1);
                    ctl_d.state  = ST_RD_BYTE;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == LAST_BIT) begin
                            ctl_d.sda_oe = 1'b0;
                            ctl_d.state  = ST_RD_ACK;
                        end else begin
                            ctl_d.sda_oe = ~ctl_q.shreg[BYTE_W-1];
                            ctl_d.shreg  = {ctl_q.shreg[BYTE_W-2:0], 1'b0};
                            ctl_d.cnt    = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ctl_d.state = sda_s ? ST_IGNORE : ST_RD_PEND;
                    end
                end
                ST_RD_PEND: begin
                    if (scl_fall) begin
                        ctl_d.rd_req = 1'b1;
                        ctl_d.state  = ST_RD_LOAD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, rx_data: '0,
                       sda_oe: 1'b0, rx_valid: 1'b0, rd_req: 1'b0, rw: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_phase   = (ctl_q.state == ST_RD_LOAD) || (ctl_q.state == ST_RD_BYTE) ||
                        (ctl_q.state == ST_RD_ACK)  || (ctl_q.state == ST_RD_PEND);
    assign sda_oe_o   = ctl_q.sda_oe;
    assign rx_data_o  = ctl_q.rx_data;
    assign rx_valid_o = ctl_q.rx_valid;
    assign rd_req_o   = ctl_q.rd_req;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic sda_oe_o,
    input logic rx_valid_o,
    input logic rd_req_o,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic tx_phase
);

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R7
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_i) && !tx_phase) |-> !$rose(sda_oe_o));

    // R8
    busy_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !$past(busy_i));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R11
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R5
    rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R4
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

endmodule

bind twi_mem_slave_if twi_mem_slave_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .sda_oe_o   (sda_oe_o),
    .rx_valid_o (rx_valid_o),
    .rd_req_o   (rd_req_o),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .tx_phase   (tx_phase)
);

// File: tb/twi_mem_slave_if_tb_top.sv
`timescale 1ns/1ps
module twi_mem_slave_if_tb_top;

    localparam int Q = 10;              // quarter SCL period in system clocks
    localparam logic [7:0] ADDR_W = 8'hA0;
    localparam logic [7:0] ADDR_R = 8'hA1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] rd_data;
    logic       rd_req;
    logic       sda_bus;

    int checks = 0;
    int failures = 0;
    int rx_cnt = 0;
    int rd_idx = 0;
    int viol = 0;
    logic [7:0] rx_log [32];
    logic [7:0] rd_mem [4];
    logic       prev_scl = 1'b1;
    logic       prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign rd_data = rd_mem[rd_idx % 4];

    initial begin
        rd_mem[0] = 8'h3C; rd_mem[1] = 8'hA5; rd_mem[2] = 8'h81; rd_mem[3] = 8'h5E;
    end

    twi_mem_slave_if dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .busy_i     (busy),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .rd_data_i  (rd_data),
        .rd_req_o   (rd_req)
    );

    always @(posedge clk) begin
        if (rx_valid) begin
            rx_log[rx_cnt % 32] <= rx_data;
            rx_cnt <= rx_cnt + 1;
        end
        if (rd_req) rd_idx <= rd_idx + 1;
        if (m_scl && prev_scl && (sda_oe != prev_oe)) viol <= viol + 1;
        prev_scl <= m_scl;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic bus_bit(input logic v, output logic s);
        m_sda = v; wq();
        m_scl = 1'b1; wq();
        s = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = {b[6:0], s};
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        chk(rd_req == 1'b0, "R1 rd_req", int'(rd_req), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    endtask

    task automatic t_write();
        logic ack;
        int base = rx_cnt;
        logic [7:0] pat [3] = '{8'h12, 8'hFF, 8'h00};
        bus_start();
        put_byte(ADDR_W, ack);
        chk(ack, "R2 address ack", int'(ack), 1);
        for (int i = 0; i < 3; i++) begin
            put_byte(pat[i], ack);
            chk(ack, "R4 data ack", int'(ack), 1);
        end
        bus_stop();
        wq();
        chk(rx_cnt - base == 3, "R4 byte count", rx_cnt - base, 3);
        for (int i = 0; i < 3; i++)
            chk(rx_log[(base + i) % 32] == pat[i], "R4 byte value",
                int'(rx_log[(base + i) % 32]), int'(pat[i]));
        chk(sda_oe == 1'b0, "R10 released after stop", int'(sda_oe), 0);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] b;
        int base = rd_idx;
        bus_start();
        put_byte(ADDR_R, ack);
        chk(ack, "R2 read address ack", int'(ack), 1);
        chk(rd_idx - base == 1, "R5 first request", rd_idx - base, 1);
        get_byte(1'b1, b);
        chk(b == rd_mem[base % 4], "R5 byte0 msb first", int'(b), int'(rd_mem[base % 4]));
        get_byte(1'b1, b);
        chk(b == rd_mem[(base + 1) % 4], "R6 byte1 after ack", int'(b), int'(rd_mem[(base + 1) % 4]));
        get_byte(1'b0, b);
        chk(b == rd_mem[(base + 2) % 4], "R6 byte2", int'(b), int'(rd_mem[(base + 2) % 4]));
        chk(rd_idx - base == 3, "R6 requests before nack", rd_idx - base, 3);
        get_byte(1'b1, b);
        chk(b == 8'hFF, "R6 released after nack", int'(b), 8'hFF);
        chk(rd_idx - base == 3, "R6 no request after nack", rd_idx - base, 3);
        bus_stop();
        wq();
    endtask

    task automatic t_mismatch();
        logic ack;
        int rbase = rx_cnt;
        int dbase = rd_idx;
        bus_start();
        put_byte(8'hA4, ack);
        chk(!ack, "R3 wrong address no ack", int'(ack), 0);
        put_byte(8'h77, ack);
        chk(!ack, "R3 data ignored", int'(ack), 0);
        bus_stop();
        wq();
        chk(rx_cnt == rbase, "R3 no rx strobe", rx_cnt - rbase, 0);
        bus_start();
        put_byte(8'hA3, ack);
        chk(!ack && rd_idx == dbase, "R3 wrong read address", int'(ack), 0);
        bus_stop();
        wq();
    endtask

    task automatic t_busy_poll();
        logic ack;
        busy = 1'b1;
        bus_start();
        put_byte(ADDR_W, ack);
        chk(!ack, "R7 busy address no ack", int'(ack), 0);
        bus_stop();
        bus_start();
        put_byte(ADDR_R, ack);
        chk(!ack, "R7 busy read address no ack", int'(ack), 0);
        bus_stop();
        busy = 1'b0;
        wq();
        bus_start();
        put_byte(ADDR_W, ack);
        chk(ack, "R7 ack after busy clears", int'(ack), 1);
        bus_stop();
        wq();
    endtask

    task automatic t_busy_mid();
        logic ack;
        int base;
        bus_start();
        put_byte(ADDR_W, ack);
        chk(ack, "R8 address ack", int'(ack), 1);
        put_byte(8'h5A, ack);
        chk(ack, "R8 first byte ack", int'(ack), 1);
        base = rx_cnt;
        busy = 1'b1;
        put_byte(8'hC3, ack);
        chk(!ack, "R8 byte under busy no ack", int'(ack), 0);
        bus_stop();
        wq();
        chk(rx_cnt == base, "R8 no rx strobe under busy", rx_cnt - base, 0);
        busy = 1'b0;
        wq();
    endtask

    task automatic t_restart();
        logic ack, s;
        logic [7:0] b;
        int base;
        bus_start();
        put_byte(ADDR_W, ack);
        put_byte(8'h11, ack);
        chk(ack, "R11 byte before restart", int'(ack), 1);
        base = rd_idx;
        bus_start();
        put_byte(ADDR_R, ack);
        chk(ack, "R11 address after restart", int'(ack), 1);
        get_byte(1'b0, b);
        chk(b == rd_mem[base % 4], "R11 read after restart", int'(b), int'(rd_mem[base % 4]));
        bus_start();
        bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
        bus_start();
        put_byte(ADDR_W, ack);
        chk(ack, "R11 restart mid address", int'(ack), 1);
        bus_stop();
        wq();
        chk(sda_oe == 1'b0, "R10 idle after stop", int'(sda_oe), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        wq();
        t_write();
        t_read();
        t_mismatch();
        t_busy_poll();
        t_busy_mid();
        t_restart();
        chk(viol == 0, "R9 drive change with SCL high", viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule